// File: doc/BRIEF.md
# Data Access Translation Unit

This block turns the virtual address of a data access into a physical address, or it reports why the access cannot go ahead. Each request carries a 64-bit virtual address, a write flag, the 2-bit processor mode, an address-space number and two qualifiers. The first qualifier is a physical-mode flag, which bypasses translation completely. The second is a page-table-access flag, which only changes the code that a miss reports. The result comes out on registered outputs one clock after the request strobe. It is either a 40-bit physical address or a fault with a 3-bit type and a 5-bit memory-management status word.

A request that is not physical takes three steps in order. First, a 43-bit canonical-address check is made. Next, a kernel-only superpage direct map is tried, enabled by one control input. Last comes a search of a small fully associative table of translations, keyed by virtual page number and address-space number, with global entries matching any address space. A hit then goes through per-mode read or write enable bits and fault-on-read or fault-on-write traps. Each outcome has its own status encoding. Table entries are written one at a time through a fill port. The fill port can also clear an entry. Walking the page table, choosing cacheability and keeping statistics belong to other blocks.

Top module: `dtlb_xlat`

## Requirements
- R1: Synchronous reset clears the response outputs to zero and marks every table entry invalid, so a lookup after reset misses.
- R2: With req_phys set, the response is no fault, status 0, and rsp_pa equal to req_va[39:0]. No other check applies.
- R3: A virtual address whose bits 63:42 are not all equal is non-canonical. It gives fault type 2 with status bit 1 (access violation) set and bit 0 equal to req_write. This check comes before any superpage or table decision.
- R4: When sp_en is set, the address is canonical and req_va[42:41] is 2'b10, a kernel-mode access (req_mode 0) gives no fault and rsp_pa = req_va[39:0]. The table is not consulted.
- R5: The same superpage access in any mode other than kernel (1 executive, 2 supervisor, 3 user) gives fault type 1 with status bit 1 set and bit 0 equal to req_write.
- R6: A table miss gives fault type 3, or fault type 4 when req_vpte is set. The status is bit 4 (miss) plus bit 0 equal to req_write.
- R7: An entry matches when it is valid, its page number equals req_va[42:13], and either its global bit is set or its address-space number equals req_asn.
- R8: A hit that passes its permission checks gives no fault, status 0 and rsp_pa = {entry frame number, req_va[12:0]}. Every faulting response drives rsp_pa to 0.
- R9: A write whose entry write-enable bit for req_mode (bit index = mode) is clear gives fault type 2 with status bits 0 and 1 set, plus bit 3 when the entry's fault-on-write bit is set.
- R10: A write with the mode's write-enable set and fault-on-write set gives fault type 2 with status bits 0 and 3 only.
- R11: A read whose entry read-enable bit for req_mode is clear gives fault type 1 with status bit 1 set, plus bit 2 when the entry's fault-on-read bit is set.
- R12: A read with the mode's read-enable set and fault-on-read set gives fault type 2 with status bit 2 only.
- R13: The response appears on the clock edge after req_valid. Without a request, all response outputs are 0. rsp_fault equals (rsp_ftype != 0). A fill is seen by lookups from the next cycle on, and a fill with fill_valid clear removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_mode | input | 2 | Current mode: 0 kernel, 1 executive, 2 supervisor, 3 user |
| req_asn | input | 8 | Current address-space number |
| req_phys | input | 1 | Physical-mode request, no translation |
| req_vpte | input | 1 | Request is a page-table access (selects miss code 4) |
| sp_en | input | 1 | Superpage direct map enable |
| fill_en | input | 1 | Write one table entry |
| fill_idx | input | 4 | Entry index to write |
| fill_valid | input | 1 | Valid bit written into the entry |
| fill_vpn | input | 30 | Virtual page number tag |
| fill_asn | input | 8 | Address-space number tag |
| fill_global | input | 1 | Entry matches every address space |
| fill_pfn | input | 27 | Physical frame number |
| fill_re | input | 4 | Per-mode read enables, bit index = mode |
| fill_we | input | 4 | Per-mode write enables, bit index = mode |
| fill_fonr | input | 1 | Fault-on-read trap bit |
| fill_fonw | input | 1 | Fault-on-write trap bit |
| rsp_valid | output | 1 | Response valid, one cycle after req_valid |
| rsp_fault | output | 1 | Response is a fault |
| rsp_ftype | output | 3 | 0 none, 1 access violation, 2 fault trap, 3 miss, 4 page-table-access miss |
| rsp_stat | output | 5 | Status: bit0 write, bit1 access violation, bit2 fault-on-read, bit3 fault-on-write, bit4 miss |
| rsp_pa | output | 40 | Physical address, 0 on a fault |

## Verification
The assertions check on every cycle the parts that the ports alone decide. These are the response timing and the idle zeros, the physical bypass, the non-canonical fault and its priority over the superpage route, and the superpage outcome by mode. They also check the miss status shape, that a fault-on-write status always carries the write bit, and that a fault clears the address. Anything that depends on the table contents can only be shown by the bench scenarios. That covers address-space and global matching, frame concatenation, the per-mode enable and trap encodings, the table shadowing the superpage region when the map is disabled, and a fill landing in the same cycle as a lookup or clearing an entry.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int VA_IN_W  = 64;
    localparam int VA_W     = 43;
    localparam int PA_W     = 40;
    localparam int PG_BITS  = 13;
    localparam int VPN_W    = VA_W - PG_BITS;
    localparam int PFN_W    = PA_W - PG_BITS;
    localparam int ASN_W    = 8;
    localparam int MODE_W   = 2;
    localparam int N_MODES  = 1 << MODE_W;
    localparam int STAT_W   = 5;
    localparam int FT_W     = 3;

    localparam int ST_WR    = 0;
    localparam int ST_ACV   = 1;
    localparam int ST_FONR  = 2;
    localparam int ST_FONW  = 3;
    localparam int ST_MISS  = 4;

    localparam logic [MODE_W-1:0] MODE_KERNEL = '0;
    localparam logic [1:0]        SP_REGION   = 2'b10;

    typedef enum logic [FT_W-1:0] {
        FT_NONE      = 3'd0,
        FT_ACV       = 3'd1,
        FT_TRAP      = 3'd2,
        FT_MISS      = 3'd3,
        FT_VPTE_MISS = 3'd4
    } ftype_e;

    typedef struct packed {
        logic               valid;
        logic [VPN_W-1:0]   vpn;
        logic [ASN_W-1:0]   asn;
        logic               glob;
    } tlb_tag_t;

    typedef struct packed {
        logic [PFN_W-1:0]   pfn;
        logic [N_MODES-1:0] rd_en;
        logic [N_MODES-1:0] wr_en;
        logic               fonr;
        logic               fonw;
    } tlb_attr_t;

    typedef struct packed {
        tlb_tag_t  tag;
        tlb_attr_t attr;
    } tlb_entry_t;

    typedef struct packed {
        logic              fault;
        ftype_e            ftype;
        logic [STAT_W-1:0] stat;
        logic [PA_W-1:0]   pa;
    } xlat_rsp_t;

    function automatic logic is_canonical(input logic [VA_IN_W-1:0] va);
        logic [VA_IN_W-VA_W:0] upper;
        upper = va[VA_IN_W-1:VA_W-1];
        return (&upper) || (~|upper);
    endfunction

endpackage

// File: rtl/dtlb_table.sv
module dtlb_table
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             hit,
    output tlb_attr_t        hit_attr
);

    logic [ENTRIES-1:0] match;
    tlb_attr_t          attr_arr [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        tlb_entry_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                q <= wr_entry;
            end
        end

        assign match[g]    = q.tag.valid && (q.tag.vpn == lk_vpn) &&
                             (q.tag.glob || (q.tag.asn == lk_asn));
        assign attr_arr[g] = q.attr;
    end

    // Lowest index wins if software ever leaves two matching entries.
    always_comb begin
        hit_attr = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit_attr = attr_arr[i];
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/dtlb_perm.sv
module dtlb_perm
    import dtlb_pkg::*;
(
    input  logic               is_write,
    input  logic [MODE_W-1:0]  mode,
    input  logic [N_MODES-1:0] rd_en,
    input  logic [N_MODES-1:0] wr_en,
    input  logic               fonr,
    input  logic               fonw,
    output logic               fault,
    output ftype_e             ftype,
    output logic [STAT_W-1:0]  stat
);

    always_comb begin
        fault = 1'b0;
        ftype = FT_NONE;
        stat  = '0;
        if (is_write) begin
            if (!wr_en[mode]) begin
                fault          = 1'b1;
                ftype          = FT_TRAP;
                stat[ST_WR]    = 1'b1;
                stat[ST_ACV]   = 1'b1;
                stat[ST_FONW]  = fonw;
            end else if (fonw) begin
                fault          = 1'b1;
                ftype          = FT_TRAP;
                stat[ST_WR]    = 1'b1;
                stat[ST_FONW]  = 1'b1;
            end
        end else begin
            if (!rd_en[mode]) begin
                fault          = 1'b1;
                ftype          = FT_ACV;
                stat[ST_ACV]   = 1'b1;
                stat[ST_FONR]  = fonr;
            end else if (fonr) begin
                fault          = 1'b1;
                ftype          = FT_TRAP;
                stat[ST_FONR]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dtlb_route.sv
module dtlb_route
    import dtlb_pkg::*;
(
    input  logic [VA_IN_W-1:0] va,
    input  logic               is_write,
    input  logic [MODE_W-1:0]  mode,
    input  logic               phys,
    input  logic               vpte,
    input  logic               sp_en,
    input  logic               hit,
    input  logic [PFN_W-1:0]   hit_pfn,
    input  logic               perm_fault,
    input  ftype_e             perm_ftype,
    input  logic [STAT_W-1:0]  perm_stat,
    output xlat_rsp_t          rsp
);

    logic canon;
    logic in_sp;

    assign canon = is_canonical(va);
    assign in_sp = sp_en && (va[VA_W-1:VA_W-2] == SP_REGION);

    always_comb begin
        rsp = '0;
        if (phys) begin
            rsp.pa = va[PA_W-1:0];
        end else if (!canon) begin
            rsp.fault        = 1'b1;
            rsp.ftype        = FT_TRAP;
            rsp.stat[ST_ACV] = 1'b1;
            rsp.stat[ST_WR]  = is_write;
        end else if (in_sp) begin
            if (mode != MODE_KERNEL) begin
                rsp.fault        = 1'b1;
                rsp.ftype        = FT_ACV;
                rsp.stat[ST_ACV] = 1'b1;
                rsp.stat[ST_WR]  = is_write;
            end else begin
                rsp.pa = va[PA_W-1:0];
            end
        end else if (!hit) begin
            rsp.fault         = 1'b1;
            rsp.ftype         = vpte ? FT_VPTE_MISS : FT_MISS;
            rsp.stat[ST_MISS] = 1'b1;
            rsp.stat[ST_WR]   = is_write;
        end else if (perm_fault) begin
            rsp.fault = 1'b1;
            rsp.ftype = perm_ftype;
            rsp.stat  = perm_stat;
        end else begin
            rsp.pa = {hit_pfn, va[PG_BITS-1:0]};
        end
    end

endmodule

// File: rtl/dtlb_xlat.sv
module dtlb_xlat
    import dtlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [VA_IN_W-1:0] req_va,
    input  logic               req_write,
    input  logic [MODE_W-1:0]  req_mode,
    input  logic [ASN_W-1:0]   req_asn,
    input  logic               req_phys,
    input  logic               req_vpte,
    input  logic               sp_en,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic               fill_valid,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [ASN_W-1:0]   fill_asn,
    input  logic               fill_global,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic [N_MODES-1:0] fill_re,
    input  logic [N_MODES-1:0] fill_we,
    input  logic               fill_fonr,
    input  logic               fill_fonw,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [FT_W-1:0]    rsp_ftype,
    output logic [STAT_W-1:0]  rsp_stat,
    output logic [PA_W-1:0]    rsp_pa
);

    tlb_entry_t        fill_entry;
    logic              tbl_hit;
    tlb_attr_t         tbl_attr;
    logic              perm_fault;
    ftype_e            perm_ftype;
    logic [STAT_W-1:0] perm_stat;
    xlat_rsp_t         rsp_d;
    xlat_rsp_t         rsp_q;

    assign fill_entry.tag.valid  = fill_valid;
    assign fill_entry.tag.vpn    = fill_vpn;
    assign fill_entry.tag.asn    = fill_asn;
    assign fill_entry.tag.glob   = fill_global;
    assign fill_entry.attr.pfn   = fill_pfn;
    assign fill_entry.attr.rd_en = fill_re;
    assign fill_entry.attr.wr_en = fill_we;
    assign fill_entry.attr.fonr  = fill_fonr;
    assign fill_entry.attr.fonw  = fill_fonw;

    dtlb_table #(.ENTRIES(ENTRIES)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (fill_en),
        .wr_idx   (fill_idx),
        .wr_entry (fill_entry),
        .lk_vpn   (req_va[VA_W-1:PG_BITS]),
        .lk_asn   (req_asn),
        .hit      (tbl_hit),
        .hit_attr (tbl_attr)
    );

    dtlb_perm u_perm (
        .is_write (req_write),
        .mode     (req_mode),
        .rd_en    (tbl_attr.rd_en),
        .wr_en    (tbl_attr.wr_en),
        .fonr     (tbl_attr.fonr),
        .fonw     (tbl_attr.fonw),
        .fault    (perm_fault),
        .ftype    (perm_ftype),
        .stat     (perm_stat)
    );

    dtlb_route u_route (
        .va         (req_va),
        .is_write   (req_write),
        .mode       (req_mode),
        .phys       (req_phys),
        .vpte       (req_vpte),
        .sp_en      (sp_en),
        .hit        (tbl_hit),
        .hit_pfn    (tbl_attr.pfn),
        .perm_fault (perm_fault),
        .perm_ftype (perm_ftype),
        .perm_stat  (perm_stat),
        .rsp        (rsp_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_q     <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_q     <= req_valid ? rsp_d : '0;
        end
    end

    assign rsp_fault = rsp_q.fault;
    assign rsp_ftype = rsp_q.ftype;
    assign rsp_stat  = rsp_q.stat;
    assign rsp_pa    = rsp_q.pa;

endmodule

// File: rtl/dtlb_xlat_chk.sv
module dtlb_xlat_chk
    import dtlb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [VA_IN_W-1:0] req_va,
    input logic               req_write,
    input logic [MODE_W-1:0]  req_mode,
    input logic               req_phys,
    input logic               sp_en,
    input logic               rsp_valid,
    input logic               rsp_fault,
    input logic [FT_W-1:0]    rsp_ftype,
    input logic [STAT_W-1:0]  rsp_stat,
    input logic [PA_W-1:0]    rsp_pa
);

    logic canon;
    logic sp_hit;

    assign canon  = is_canonical(req_va);
    assign sp_hit = req_valid && !req_phys && canon && sp_en &&
                    (req_va[VA_W-1:VA_W-2] == SP_REGION);

    AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R13

    AST_RSP_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!rsp_valid && !rsp_fault && rsp_stat == '0 && rsp_pa == '0)); // R13

    AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (rst)
        rsp_fault == (rsp_ftype != 3'd0)); // R13

    AST_PHYS_PASS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_phys) |=> (!rsp_fault && rsp_stat == '0 &&
                                     rsp_pa == $past(req_va[PA_W-1:0]))); // R2

    AST_NONCANON_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_phys && !canon) |=>
            (rsp_ftype == 3'd2 && rsp_stat == {3'b000, 1'b1, $past(req_write)})); // R3

    AST_SP_KERNEL: assert property (@(posedge clk) disable iff (rst)
        (sp_hit && req_mode == MODE_KERNEL) |=>
            (!rsp_fault && rsp_pa == $past(req_va[PA_W-1:0]))); // R4

    AST_SP_NONKERNEL: assert property (@(posedge clk) disable iff (rst)
        (sp_hit && req_mode != MODE_KERNEL) |=>
            (rsp_ftype == 3'd1 && rsp_stat == {3'b000, 1'b1, $past(req_write)})); // R5

    AST_MISS_STAT: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && (rsp_ftype == 3'd3 || rsp_ftype == 3'd4)) |->
            (rsp_stat[ST_MISS] && rsp_stat[3:1] == 3'b000)); // R6

    AST_FONW_HAS_WR: assert property (@(posedge clk) disable iff (rst)
        rsp_stat[ST_FONW] |-> rsp_stat[ST_WR]); // R10

    AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_pa == '0)); // R8

endmodule

bind dtlb_xlat dtlb_xlat_chk u_chk (.*);

// File: tb/sim_dtlb_xlat.sv
`timescale 1ns/1ps
module sim_dtlb_xlat;
    import dtlb_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic [63:0]        req_va = '0;
    logic               req_write = 1'b0;
    logic [1:0]         req_mode = '0;
    logic [7:0]         req_asn = '0;
    logic               req_phys = 1'b0;
    logic               req_vpte = 1'b0;
    logic               sp_en = 1'b0;
    logic               fill_en = 1'b0;
    logic [3:0]         fill_idx = '0;
    logic               fill_valid = 1'b0;
    logic [29:0]        fill_vpn = '0;
    logic [7:0]         fill_asn = '0;
    logic               fill_global = 1'b0;
    logic [26:0]        fill_pfn = '0;
    logic [3:0]         fill_re = '0;
    logic [3:0]         fill_we = '0;
    logic               fill_fonr = 1'b0;
    logic               fill_fonw = 1'b0;
    logic               rsp_valid;
    logic               rsp_fault;
    logic [2:0]         rsp_ftype;
    logic [4:0]         rsp_stat;
    logic [39:0]        rsp_pa;

    always #10 clk = ~clk;

    dtlb_xlat u0 (.*);

    // Behavioural model state
    bit          m_v   [16];
    logic [29:0] m_vpn [16];
    logic [7:0]  m_asn [16];
    bit          m_g   [16];
    logic [26:0] m_pfn [16];
    logic [3:0]  m_re  [16];
    logic [3:0]  m_we  [16];
    bit          m_fr  [16];
    bit          m_fw  [16];

    logic        e_valid, e_fault;
    logic [2:0]  e_type;
    logic [4:0]  e_stat;
    logic [39:0] e_pa;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    function automatic logic [63:0] mk_va(input logic [29:0] vpn, input logic [12:0] off);
        return {{21{vpn[29]}}, vpn, off};
    endfunction

    task automatic model();
        int hit_i;
        bit canon;
        e_valid = 1'b0; e_fault = 1'b0; e_type = 3'd0; e_stat = 5'd0; e_pa = '0;
        if (rst || !req_valid) return;
        e_valid = 1'b1;
        canon = (req_va[63:42] == '0) || (req_va[63:42] == '1);
        if (req_phys) begin
            e_pa = req_va[39:0];
        end else if (!canon) begin
            e_type = 3'd2; e_stat = {3'b000, 1'b1, req_write};
        end else if (sp_en && req_va[42:41] == 2'b10) begin
            if (req_mode != 2'd0) begin
                e_type = 3'd1; e_stat = {3'b000, 1'b1, req_write};
            end else begin
                e_pa = req_va[39:0];
            end
        end else begin
            hit_i = -1;
            for (int i = 0; i < 16; i++) begin
                if (hit_i < 0 && m_v[i] && m_vpn[i] == req_va[42:13] &&
                    (m_g[i] || m_asn[i] == req_asn)) hit_i = i;
            end
            if (hit_i < 0) begin
                e_type = req_vpte ? 3'd4 : 3'd3;
                e_stat = {4'b1000, req_write};
            end else if (req_write) begin
                if (!m_we[hit_i][req_mode]) begin
                    e_type = 3'd2; e_stat = {1'b0, m_fw[hit_i], 3'b011};
                end else if (m_fw[hit_i]) begin
                    e_type = 3'd2; e_stat = 5'b01001;
                end else begin
                    e_pa = {m_pfn[hit_i], req_va[12:0]};
                end
            end else begin
                if (!m_re[hit_i][req_mode]) begin
                    e_type = 3'd1; e_stat = {2'b00, m_fr[hit_i], 2'b10};
                end else if (m_fr[hit_i]) begin
                    e_type = 3'd2; e_stat = 5'b00100;
                end else begin
                    e_pa = {m_pfn[hit_i], req_va[12:0]};
                end
            end
        end
        e_fault = (e_type != 3'd0);
    endtask

    task automatic model_update();
        if (rst) begin
            for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
        end else if (fill_en) begin
            m_v[fill_idx]   = fill_valid;
            m_vpn[fill_idx] = fill_vpn;
            m_asn[fill_idx] = fill_asn;
            m_g[fill_idx]   = fill_global;
            m_pfn[fill_idx] = fill_pfn;
            m_re[fill_idx]  = fill_re;
            m_we[fill_idx]  = fill_we;
            m_fr[fill_idx]  = fill_fonr;
            m_fw[fill_idx]  = fill_fonw;
        end
    endtask

    task automatic compare(input string tag);
        n_chk++;
        if (rsp_valid !== e_valid || rsp_fault !== e_fault || rsp_ftype !== e_type ||
            rsp_stat !== e_stat || rsp_pa !== e_pa) begin
            n_fail++;
            $display("FAIL %s: got v=%b f=%b t=%0d s=%b pa=%h, expected v=%b f=%b t=%0d s=%b pa=%h",
                     tag, rsp_valid, rsp_fault, rsp_ftype, rsp_stat, rsp_pa,
                     e_valid, e_fault, e_type, e_stat, e_pa);
        end
    endtask

    // One clock: model from current inputs, edge, sample at the falling edge.
    task automatic cycle(input string tag);
        model();
        model_update();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic lookup(input logic [63:0] va, input logic wr, input logic [1:0] mode,
                          input logic [7:0] asn, input logic phys, input logic vpte,
                          input string tag);
        req_valid = 1'b1; req_va = va; req_write = wr; req_mode = mode;
        req_asn = asn; req_phys = phys; req_vpte = vpte;
        cycle(tag);
        req_valid = 1'b0;
    endtask

    task automatic fill(input int idx, input logic v, input logic [29:0] vpn,
                        input logic [7:0] asn, input logic g, input logic [26:0] pfn,
                        input logic [3:0] re, input logic [3:0] we,
                        input logic fr, input logic fw);
        fill_en = 1'b1; fill_idx = 4'(idx); fill_valid = v; fill_vpn = vpn;
        fill_asn = asn; fill_global = g; fill_pfn = pfn; fill_re = re;
        fill_we = we; fill_fonr = fr; fill_fonw = fw;
        cycle("R13");
        fill_en = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle("R1");
        cycle("R1");
        rst = 1'b0;
        cycle("R1");
        // empty table after reset: miss
        lookup(mk_va(30'h0000_1234, 13'h0010), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R1");

        fill(0,  1, 30'h0000_1234, 8'd5, 0, 27'h123_4567, 4'b1111, 4'b0001, 0, 0);
        fill(1,  1, 30'h0000_2000, 8'd9, 1, 27'h0AB_CDEF, 4'b0001, 4'b0000, 0, 0);
        fill(2,  1, 30'h3FFF_FF00, 8'd5, 0, 27'h7FF_FFFF, 4'b1111, 4'b0000, 0, 1);
        fill(3,  1, 30'h0000_3000, 8'd5, 0, 27'h000_0001, 4'b1111, 4'b1111, 0, 1);
        fill(4,  1, 30'h0000_4000, 8'd5, 0, 27'h555_5555, 4'b0000, 4'b1111, 0, 0);
        fill(5,  1, 30'h0000_5000, 8'd5, 0, 27'h0C0_FFEE, 4'b0001, 4'b0000, 1, 0);
        fill(15, 1, 30'h2000_0001, 8'd5, 0, 27'h111_1111, 4'b1111, 4'b1111, 0, 0);

        // R8 hits
        lookup(mk_va(30'h0000_1234, 13'h1ABC), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R8");
        lookup(mk_va(30'h0000_1234, 13'h0007), 1'b0, 2'd3, 8'd5, 1'b0, 1'b0, "R8");
        lookup(mk_va(30'h0000_1234, 13'h1FFF), 1'b1, 2'd0, 8'd5, 1'b0, 1'b0, "R8");
        lookup(mk_va(30'h3FFF_FF00, 13'h0123), 1'b0, 2'd2, 8'd5, 1'b0, 1'b0, "R8");
        // R7 matching
        lookup(mk_va(30'h0000_1234, 13'h0000), 1'b0, 2'd0, 8'd6, 1'b0, 1'b0, "R7");
        lookup(mk_va(30'h0000_2000, 13'h0444), 1'b0, 2'd0, 8'd200, 1'b0, 1'b0, "R7");
        // R12 / R11 read checks
        lookup(mk_va(30'h0000_5000, 13'h0008), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R12");
        lookup(mk_va(30'h0000_5000, 13'h0008), 1'b0, 2'd3, 8'd5, 1'b0, 1'b0, "R11");
        lookup(mk_va(30'h0000_4000, 13'h0008), 1'b0, 2'd1, 8'd5, 1'b0, 1'b0, "R11");
        lookup(mk_va(30'h0000_2000, 13'h0008), 1'b0, 2'd2, 8'd77, 1'b0, 1'b0, "R11");
        // R9 / R10 write checks
        lookup(mk_va(30'h0000_1234, 13'h0020), 1'b1, 2'd3, 8'd5, 1'b0, 1'b0, "R9");
        lookup(mk_va(30'h3FFF_FF00, 13'h0020), 1'b1, 2'd0, 8'd5, 1'b0, 1'b0, "R9");
        lookup(mk_va(30'h0000_3000, 13'h0020), 1'b1, 2'd1, 8'd5, 1'b0, 1'b0, "R10");
        lookup(mk_va(30'h0000_4000, 13'h0ABC), 1'b1, 2'd2, 8'd5, 1'b0, 1'b0, "R8");
        // R6 misses
        lookup(mk_va(30'h0000_7777, 13'h0000), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R6");
        lookup(mk_va(30'h0000_7777, 13'h0000), 1'b1, 2'd0, 8'd5, 1'b0, 1'b1, "R6");
        // R2 physical bypass, even for a non-canonical address
        lookup(mk_va(30'h0000_7777, 13'h0F0F) ^ 64'h0004_0000_0000_0000, 1'b1, 2'd3, 8'd1, 1'b1, 1'b0, "R2");
        lookup(mk_va(30'h0000_1234, 13'h0001), 1'b0, 2'd0, 8'd5, 1'b1, 1'b0, "R2");
        // R3 non-canonical
        lookup(mk_va(30'h0000_1234, 13'h0001) ^ 64'h0004_0000_0000_0000, 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R3");
        lookup(mk_va(30'h0000_1234, 13'h0001) ^ 64'h8000_0000_0000_0000, 1'b1, 2'd0, 8'd5, 1'b0, 1'b0, "R3");
        sp_en = 1'b1;
        lookup(mk_va(30'h2000_0001, 13'h0001) ^ 64'h0100_0000_0000_0000, 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R3");
        // R4 / R5 superpage
        lookup(mk_va(30'h2000_0001, 13'h1234), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R4");
        lookup(mk_va(30'h2ABC_DEF0, 13'h0042), 1'b1, 2'd0, 8'd99, 1'b0, 1'b0, "R4");
        lookup(mk_va(30'h2000_0001, 13'h1234), 1'b1, 2'd3, 8'd5, 1'b0, 1'b0, "R5");
        lookup(mk_va(30'h2000_0001, 13'h1234), 1'b0, 2'd2, 8'd5, 1'b0, 1'b0, "R5");
        sp_en = 1'b0;
        lookup(mk_va(30'h2000_0001, 13'h1234), 1'b0, 2'd3, 8'd5, 1'b0, 1'b0, "R4");
        lookup(mk_va(30'h2ABC_DEF0, 13'h0042), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R6");
        // R13 fill in the same cycle as a lookup of that page
        req_valid = 1'b1; req_va = mk_va(30'h0000_6000, 13'h0055); req_write = 1'b0;
        req_mode = 2'd0; req_asn = 8'd5; req_phys = 1'b0; req_vpte = 1'b0;
        fill_en = 1'b1; fill_idx = 4'd6; fill_valid = 1'b1; fill_vpn = 30'h0000_6000;
        fill_asn = 8'd5; fill_global = 1'b0; fill_pfn = 27'h06A_0B0C;
        fill_re = 4'b1111; fill_we = 4'b1111; fill_fonr = 1'b0; fill_fonw = 1'b0;
        cycle("R13");
        fill_en = 1'b0;
        cycle("R13");
        req_valid = 1'b0;
        cycle("R13");
        fill(6, 0, 30'h0000_6000, 8'd5, 0, 27'h06A_0B0C, 4'b1111, 4'b1111, 0, 0);
        lookup(mk_va(30'h0000_6000, 13'h0055), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R13");
        cycle("R13");
        // reset again clears the table
        rst = 1'b1;
        cycle("R1");
        rst = 1'b0;
        lookup(mk_va(30'h0000_1234, 13'h1ABC), 1'b0, 2'd0, 8'd5, 1'b0, 1'b0, "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule